// File: doc/BRIEF.md
# NAND flash opcode sequencer

This block carries out a short programmed list of NAND flash bus operations without processor help. Before each run, software sets up a 32-bit sequence word made of eight 4-bit opcodes and a 32-bit command word made of four command bytes. A start pulse latches both words. The sequencer then walks the opcode slots and drives a byte-wide NAND interface. That interface has a command-latch strobe, an address-latch strobe, a write-data strobe, a read-data strobe and a ready/busy input. The sequencer stops at the first zero opcode or after the last slot.

Bulk transfers move through a plain byte-stream port to and from an outside buffer, one byte per bus cycle. Single data bytes and user-chosen address bytes come from a 32-bit user data register, or go into it. The wait-type opcodes hold the sequence until the synchronized ready/busy line is high or a programmable cycle limit runs out. If the limit runs out, a sticky timeout flag is raised and the step goes ahead anyway.

Top module: `nand_opseq`

## Requirements
- R1: The opcode in bits 31:28 of `seq_word` runs first, then each lower nibble in turn. When the opcode in bits 3:0 finishes, the run ends.
- R2: Opcode 0x0 ends the run at once, and no later slot runs. At the end of every run `done` is high for exactly one cycle, and `busy` is low from that same cycle on.
- R3: Opcodes 0x4 to 0x7 each give one bus cycle with `nf_cle` and `nf_we` high. The byte driven is command byte 0 to 3, where byte 0 is bits 31:24 of `cmd_word` and byte 3 is bits 7:0. No bus cycle ever has more than one of `nf_cle`, `nf_ale` and `nf_re` high.
- R4: Opcode 0x1 drives `col_addr` as 2 bytes when `col_wide` is 1 and as 1 byte when it is 0. Opcode 0x2 drives `row_len`+1 bytes of `row_addr`. Both send the least significant byte first, with `nf_ale` and `nf_we` high.
- R5: Opcode 0x3 drives one address byte from the user register. Opcode 0x9 writes one data byte from the user register. Opcode 0xB reads one byte from `nf_din` into the user register. These three opcodes share a single field pointer. The pointer starts at bits 31:24 at every start and moves one byte toward bit 0 after each use.
- R6: Opcode 0x8 writes `xfer_len` bytes taken from `buf_tx_data`, pulsing `buf_tx_rd` for each byte. Opcode 0xA reads `xfer_len` bytes and presents each one on `buf_rx_data` with `buf_rx_wr` high. A length of 0 moves no bytes.
- R7: Opcodes 0xC and 0xD wait for the synchronized `nf_rb` to be high, then issue command byte 0 or command byte 1. Opcode 0xE waits the same way, then does a bulk read. Opcode 0xF waits the same way, then does a single-byte read into the user register.
- R8: If `nf_rb` stays low for `tmo_limit` waiting cycles (a limit of 0 counts as 1), the sequencer sets `tmo_flag` and goes ahead with the step. The flag stays set until the next accepted start.
- R9: While `busy` is high, a `start` pulse is ignored and a software write to the user register is ignored.
- R10: After reset, `busy`, `done` and `tmo_flag` are 0, every NAND strobe is 0, and `udr_q` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, accepted only while idle |
| seq_word | input | 32 | Eight 4-bit opcodes, latched at start |
| cmd_word | input | 32 | Four command bytes, latched at start |
| col_addr | input | 16 | Column address |
| row_addr | input | 32 | Block and page address |
| col_wide | input | 1 | 1 selects 2 column bytes, 0 selects 1 |
| row_len | input | 2 | Number of row bytes minus one |
| xfer_len | input | 12 | Byte count for bulk transfers |
| tmo_limit | input | 16 | Ready-wait limit in cycles |
| udr_we | input | 1 | Software write strobe for the user register |
| udr_wdata | input | 32 | Software write data for the user register |
| udr_q | output | 32 | User register contents |
| nf_cle | output | 1 | Command-latch strobe |
| nf_ale | output | 1 | Address-latch strobe |
| nf_we | output | 1 | Write strobe, one cycle per byte driven |
| nf_re | output | 1 | Read strobe, one cycle per byte read |
| nf_oe | output | 1 | Output enable for `nf_dout` |
| nf_dout | output | 8 | Byte driven to the flash |
| nf_din | input | 8 | Byte from the flash, captured at the end of a read cycle |
| nf_rb | input | 1 | Ready/busy, high when ready |
| buf_tx_rd | output | 1 | Pops one byte from the transmit stream |
| buf_tx_data | input | 8 | Current transmit-stream byte |
| buf_rx_wr | output | 1 | Pushes one byte to the receive stream |
| buf_rx_data | output | 8 | Byte pushed to the receive stream |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| tmo_flag | output | 1 | Sticky ready-wait timeout flag |

## Verification
The hardest cases to reach from the ports are the middle of a ready wait, where a second start and a software write to the user register must both be lost, and a wait that ends by timeout rather than by ready. To reach them, the bench holds `nf_rb` low while a wait opcode is pending. It sends the competing start and register write during that hold, then releases the line and checks that only the first program ran. A second run with a short limit and the line held low makes the timeout fire. A further run shows the flag cleared by the next start.

// File: rtl/nseq_pkg.sv
package nseq_pkg;

   localparam int unsigned NSEQ_OP_W = 4;

   typedef enum logic [3:0] {
      ACT_NOP,
      ACT_CMD,
      ACT_COL,
      ACT_ROW,
      ACT_UADDR,
      ACT_BWR,
      ACT_SWR,
      ACT_BRD,
      ACT_SRD
   } act_e;

   typedef struct packed {
      act_e       act;
      logic       wait_rdy;
      logic [1:0] cmd_sel;
   } step_t;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_FETCH,
      ST_WAIT,
      ST_XFER
   } st_e;

endpackage

// File: rtl/nseq_decode.sv
module nseq_decode
   import nseq_pkg::*;
#(
   parameter int unsigned OPW = 4
)(
   input  logic [OPW-1:0] op,
   output step_t          step
);

   generate
      if (OPW != NSEQ_OP_W) begin : g_bad_opw
         $error("nseq_decode: opcode width must be %0d", NSEQ_OP_W);
      end
   endgenerate

   always_comb begin
      step          = '0;
      step.act      = ACT_NOP;
      step.wait_rdy = 1'b0;
      step.cmd_sel  = 2'd0;
      unique case (op)
         4'h0: step.act = ACT_NOP;
         4'h1: step.act = ACT_COL;
         4'h2: step.act = ACT_ROW;
         4'h3: step.act = ACT_UADDR;
         4'h4, 4'h5, 4'h6, 4'h7: begin
            step.act     = ACT_CMD;
            step.cmd_sel = op[1:0];
         end
         4'h8: step.act = ACT_BWR;
         4'h9: step.act = ACT_SWR;
         4'hA: step.act = ACT_BRD;
         4'hB: step.act = ACT_SRD;
         4'hC, 4'hD: begin
            step.act      = ACT_CMD;
            step.wait_rdy = 1'b1;
            step.cmd_sel  = {1'b0, op[0]};
         end
         4'hE: begin
            step.act      = ACT_BRD;
            step.wait_rdy = 1'b1;
         end
         default: begin
            step.act      = ACT_SRD;
            step.wait_rdy = 1'b1;
         end
      endcase
   end

endmodule

// File: rtl/nseq_sync.sv
module nseq_sync #(
   parameter int unsigned STAGES = 2
)(
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES > 4) begin : g_bad_stages
         $error("nseq_sync: at most 4 stages");
      end
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] sr_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr_q <= '0;
            else        sr_q <= {sr_q[STAGES-2 >= 0 ? STAGES-2 : 0 : 0], d} & {STAGES{1'b1}};
         end
         assign q = sr_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/nseq_timer.sv
module nseq_timer #(
   parameter int unsigned TW = 16
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          rdy,
   input  logic [TW-1:0] limit,
   output logic          pass,
   output logic          expire
);

   logic [TW-1:0] cnt_q;
   logic [TW:0]   lim_eff;
   logic          at_end;

   generate
      if (TW < 2) begin : g_bad_tw
         $error("nseq_timer: counter width too small");
      end
   endgenerate

   assign lim_eff = (limit == '0) ? (TW+1)'(1) : {1'b0, limit};
   assign at_end  = ({1'b0, cnt_q} + (TW+1)'(1)) >= lim_eff;
   assign expire  = run && !rdy && at_end;
   assign pass    = run && (rdy || at_end);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (!run || pass)  cnt_q <= '0;
      else                    cnt_q <= cnt_q + TW'(1);
   end

   // R8: a wait that does not finish leaves a nonzero cycle count behind
   assert_wait_counts_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !pass) |=> (cnt_q != '0));

   // R8: a wait whose ready line is high never reports a timeout
   assert_no_tmo_when_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (run && rdy) |-> !expire);

endmodule

// File: rtl/nseq_udr.sv
module nseq_udr #(
   parameter int unsigned DW = 32,
   parameter int unsigned BW = 8
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          busy,
   input  logic          sw_we,
   input  logic [DW-1:0] sw_wdata,
   input  logic          clr_ptr,
   input  logic          adv,
   input  logic          cap,
   input  logic [BW-1:0] cap_byte,
   output logic [BW-1:0] cur_byte,
   output logic [DW-1:0] q
);

   localparam int unsigned NF = DW / BW;
   localparam int unsigned PW = (NF > 1) ? $clog2(NF) : 1;

   generate
      if (DW % BW != 0 || NF < 1) begin : g_bad_dw
         $error("nseq_udr: width must be a whole number of bytes");
      end
   endgenerate

   logic [PW-1:0] ptr_q;
   int            fld;

   assign fld      = int'(NF - 1) - int'(ptr_q);
   assign cur_byte = q[BW*fld +: BW];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q     <= '0;
         ptr_q <= '0;
      end else begin
         if (!busy && sw_we) q <= sw_wdata;
         else if (cap)       q[BW*fld +: BW] <= cap_byte;
         if (clr_ptr)        ptr_q <= '0;
         else if (adv)       ptr_q <= (ptr_q == PW'(NF-1)) ? '0 : ptr_q + PW'(1);
      end
   end

   // R5: every run begins at the most significant field
   assert_ptr_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
      clr_ptr |=> (ptr_q == '0));

   // R9: software writes are lost while a run owns the register
   assert_sw_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && sw_we && !cap) |=> $stable(q));

endmodule

// File: rtl/nand_opseq.sv
module nand_opseq
   import nseq_pkg::*;
#(
   parameter int unsigned SLOTS       = 8,
   parameter int unsigned OPW         = 4,
   parameter int unsigned BYTE_W      = 8,
   parameter int unsigned CMD_W       = 32,
   parameter int unsigned UDR_W       = 32,
   parameter int unsigned COL_W       = 16,
   parameter int unsigned ROW_W       = 32,
   parameter int unsigned CNT_W       = 12,
   parameter int unsigned TMO_W       = 16,
   parameter int unsigned SYNC_STAGES = 2
)(
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            start,
   input  logic [SLOTS*OPW-1:0]            seq_word,
   input  logic [CMD_W-1:0]                cmd_word,
   input  logic [COL_W-1:0]                col_addr,
   input  logic [ROW_W-1:0]                row_addr,
   input  logic                            col_wide,
   input  logic [$clog2(ROW_W/BYTE_W)-1:0] row_len,
   input  logic [CNT_W-1:0]                xfer_len,
   input  logic [TMO_W-1:0]                tmo_limit,
   input  logic                            udr_we,
   input  logic [UDR_W-1:0]                udr_wdata,
   output logic [UDR_W-1:0]                udr_q,
   output logic                            nf_cle,
   output logic                            nf_ale,
   output logic                            nf_we,
   output logic                            nf_re,
   output logic                            nf_oe,
   output logic [BYTE_W-1:0]               nf_dout,
   input  logic [BYTE_W-1:0]               nf_din,
   input  logic                            nf_rb,
   output logic                            buf_tx_rd,
   input  logic [BYTE_W-1:0]               buf_tx_data,
   output logic                            buf_rx_wr,
   output logic [BYTE_W-1:0]               buf_rx_data,
   output logic                            busy,
   output logic                            done,
   output logic                            tmo_flag
);

   localparam int unsigned SLW = (SLOTS > 1) ? $clog2(SLOTS) : 1;
   localparam int unsigned BIW = $clog2(ROW_W / BYTE_W) + 1;
   localparam int unsigned NCMD = CMD_W / BYTE_W;

   generate
      if (CMD_W != 4*BYTE_W) begin : g_bad_cmd
         $error("nand_opseq: command word must hold four bytes");
      end
      if (CNT_W < BIW) begin : g_bad_cnt
         $error("nand_opseq: byte counter too narrow for address lengths");
      end
      if (COL_W != 2*BYTE_W) begin : g_bad_col
         $error("nand_opseq: column address must be two bytes");
      end
      if (ROW_W % BYTE_W != 0) begin : g_bad_row
         $error("nand_opseq: row address must be whole bytes");
      end
   endgenerate

   st_e                  st_q;
   logic [SLW-1:0]       slot_q;
   logic [SLOTS*OPW-1:0] seq_q;
   logic [CMD_W-1:0]     cmd_q;
   step_t                step_q;
   step_t                step_f;
   logic [CNT_W-1:0]     left_q;
   logic [BIW-1:0]       bidx_q;
   logic [OPW-1:0]       cur_op;
   logic [CNT_W-1:0]     step_len;
   logic                 start_go;
   logic                 rb_s;
   logic                 tm_pass;
   logic                 tm_expire;
   logic                 active;
   logic                 last_slot;
   logic [BYTE_W-1:0]    udr_byte;
   logic [BYTE_W-1:0]    cmd_byte;
   logic [COL_W-1:0]     col_sh;
   logic [ROW_W-1:0]     row_sh;

   assign start_go  = start && !busy;
   assign last_slot = (slot_q == SLW'(SLOTS-1));
   assign cur_op    = seq_q[OPW*(int'(SLOTS-1) - int'(slot_q)) +: OPW];

   nseq_decode #(.OPW(OPW)) u_dec (
      .op   (cur_op),
      .step (step_f)
   );

   nseq_sync #(.STAGES(SYNC_STAGES)) u_rbsync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (nf_rb),
      .q     (rb_s)
   );

   nseq_timer #(.TW(TMO_W)) u_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (st_q == ST_WAIT),
      .rdy    (rb_s),
      .limit  (tmo_limit),
      .pass   (tm_pass),
      .expire (tm_expire)
   );

   always_comb begin
      unique case (step_f.act)
         ACT_COL:          step_len = col_wide ? CNT_W'(2) : CNT_W'(1);
         ACT_ROW:          step_len = CNT_W'(row_len) + CNT_W'(1);
         ACT_BWR, ACT_BRD: step_len = xfer_len;
         default:          step_len = CNT_W'(1);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         slot_q   <= '0;
         seq_q    <= '0;
         cmd_q    <= '0;
         step_q   <= '0;
         left_q   <= '0;
         bidx_q   <= '0;
         busy     <= 1'b0;
         done     <= 1'b0;
         tmo_flag <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               if (start_go) begin
                  seq_q    <= seq_word;
                  cmd_q    <= cmd_word;
                  slot_q   <= '0;
                  busy     <= 1'b1;
                  tmo_flag <= 1'b0;
                  st_q     <= ST_FETCH;
               end
            end
            ST_FETCH: begin
               if (step_f.act == ACT_NOP) begin
                  st_q <= ST_IDLE;
                  busy <= 1'b0;
                  done <= 1'b1;
               end else begin
                  step_q <= step_f;
                  left_q <= step_len;
                  bidx_q <= '0;
                  st_q   <= step_f.wait_rdy ? ST_WAIT : ST_XFER;
               end
            end
            ST_WAIT: begin
               if (tm_pass) begin
                  if (tm_expire) tmo_flag <= 1'b1;
                  st_q <= ST_XFER;
               end
            end
            default: begin
               if (left_q > CNT_W'(1)) begin
                  left_q <= left_q - CNT_W'(1);
                  bidx_q <= bidx_q + BIW'(1);
               end else begin
                  left_q <= '0;
                  if (last_slot) begin
                     st_q <= ST_IDLE;
                     busy <= 1'b0;
                     done <= 1'b1;
                  end else begin
                     slot_q <= slot_q + SLW'(1);
                     st_q   <= ST_FETCH;
                  end
               end
            end
         endcase
      end
   end

   assign active = (st_q == ST_XFER) && (left_q != '0);

   nseq_udr #(.DW(UDR_W), .BW(BYTE_W)) u_udr (
      .clk      (clk),
      .rst_n    (rst_n),
      .busy     (busy),
      .sw_we    (udr_we),
      .sw_wdata (udr_wdata),
      .clr_ptr  (start_go),
      .adv      (active && (step_q.act == ACT_UADDR || step_q.act == ACT_SWR ||
                            step_q.act == ACT_SRD)),
      .cap      (active && step_q.act == ACT_SRD),
      .cap_byte (nf_din),
      .cur_byte (udr_byte),
      .q        (udr_q)
   );

   assign cmd_byte = cmd_q[CMD_W - BYTE_W*(int'(step_q.cmd_sel) + 1) +: BYTE_W];
   assign col_sh   = col_addr >> (BYTE_W * int'(bidx_q));
   assign row_sh   = row_addr >> (BYTE_W * int'(bidx_q));

   always_comb begin
      nf_cle  = 1'b0;
      nf_ale  = 1'b0;
      nf_we   = 1'b0;
      nf_re   = 1'b0;
      nf_dout = '0;
      if (active) begin
         unique case (step_q.act)
            ACT_CMD: begin
               nf_cle = 1'b1; nf_we = 1'b1; nf_dout = cmd_byte;
            end
            ACT_COL: begin
               nf_ale = 1'b1; nf_we = 1'b1; nf_dout = col_sh[BYTE_W-1:0];
            end
            ACT_ROW: begin
               nf_ale = 1'b1; nf_we = 1'b1; nf_dout = row_sh[BYTE_W-1:0];
            end
            ACT_UADDR: begin
               nf_ale = 1'b1; nf_we = 1'b1; nf_dout = udr_byte;
            end
            ACT_SWR: begin
               nf_we = 1'b1; nf_dout = udr_byte;
            end
            ACT_BWR: begin
               nf_we = 1'b1; nf_dout = buf_tx_data;
            end
            ACT_BRD, ACT_SRD: nf_re = 1'b1;
            default: ;
         endcase
      end
   end

   assign nf_oe       = nf_we;
   assign buf_tx_rd   = active && (step_q.act == ACT_BWR);
   assign buf_rx_wr   = active && (step_q.act == ACT_BRD);
   assign buf_rx_data = nf_din;

   // R3: latch strobes and the read strobe never overlap
   assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({nf_cle, nf_ale, nf_re}) && !(nf_we && nf_re));

   // R2: completion is a single-cycle pulse
   assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R2: busy is already low when completion is flagged
   assert_done_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R10: an idle sequencer leaves the flash bus quiet
   assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !(nf_cle || nf_ale || nf_we || nf_re || buf_tx_rd || buf_rx_wr));

   // R8: the timeout flag holds for the rest of the run
   assert_tmo_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && tmo_flag) |=> tmo_flag);

   // R9: a start during a run neither restarts nor stops it early
   assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && st_q != ST_XFER && st_q != ST_FETCH) |=> busy);

   // R1: a new run always begins in slot 0
   assert_slot_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      start_go |=> (slot_q == '0));

endmodule

// File: tb/tb_nand_opseq.sv
`timescale 1ns/1ps
module tb_nand_opseq;

   typedef struct packed {
      logic [31:0] op;
      logic [7:0]  cle;
      logic [7:0]  ale;
      logic [7:0]  we;
      logic [7:0]  re;
      logic [7:0]  lastc;
   } vec_t;

   // cmd_word 0x60D070FF, 2 column bytes, 3 row bytes, bulk length 4, ready high
   localparam vec_t VT [8] = '{
      '{32'h4120_0000, 8'd1, 8'd5, 8'd6,  8'd0, 8'h60},
      '{32'h7000_0000, 8'd1, 8'd0, 8'd1,  8'd0, 8'hFF},
      '{32'h5BA0_0000, 8'd1, 8'd0, 8'd1,  8'd5, 8'hD0},
      '{32'h4381_C600, 8'd3, 8'd3, 8'd10, 8'd0, 8'h70},
      '{32'h0444_4444, 8'd0, 8'd0, 8'd0,  8'd0, 8'h00},
      '{32'h6767_6767, 8'd8, 8'd0, 8'd8,  8'd0, 8'hFF},
      '{32'hEF9D_0000, 8'd1, 8'd0, 8'd2,  8'd5, 8'hD0},
      '{32'h1234_5678, 8'd4, 8'd6, 8'd14, 8'd0, 8'hFF}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] seq_word = '0;
   logic [31:0] cmd_word = 32'h60D0_70FF;
   logic [15:0] col_addr = 16'hBEEF;
   logic [31:0] row_addr = 32'h0012_3456;
   logic        col_wide = 1'b1;
   logic [1:0]  row_len = 2'd2;
   logic [11:0] xfer_len = 12'd4;
   logic [15:0] tmo_limit = 16'd100;
   logic        udr_we = 1'b0;
   logic [31:0] udr_wdata = '0;
   logic [31:0] udr_q;
   logic        nf_cle, nf_ale, nf_we, nf_re, nf_oe;
   logic [7:0]  nf_dout, nf_din;
   logic        nf_rb = 1'b1;
   logic        buf_tx_rd, buf_rx_wr;
   logic [7:0]  buf_tx_data, buf_rx_data;
   logic        busy, done, tmo_flag;

   always #2.5 clk = ~clk;

   nand_opseq dut (
      .clk(clk), .rst_n(rst_n), .start(start), .seq_word(seq_word), .cmd_word(cmd_word),
      .col_addr(col_addr), .row_addr(row_addr), .col_wide(col_wide), .row_len(row_len),
      .xfer_len(xfer_len), .tmo_limit(tmo_limit), .udr_we(udr_we), .udr_wdata(udr_wdata),
      .udr_q(udr_q), .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_we(nf_we), .nf_re(nf_re),
      .nf_oe(nf_oe), .nf_dout(nf_dout), .nf_din(nf_din), .nf_rb(nf_rb),
      .buf_tx_rd(buf_tx_rd), .buf_tx_data(buf_tx_data), .buf_rx_wr(buf_rx_wr),
      .buf_rx_data(buf_rx_data), .busy(busy), .done(done), .tmo_flag(tmo_flag)
   );

   // flash read data and transmit stream models
   logic       rd_ld = 1'b0;
   logic [7:0] rd_seed = 8'h00;
   logic [7:0] rd_byte = 8'h00;
   logic [7:0] tx_cnt = 8'h00;
   assign nf_din      = rd_byte;
   assign buf_tx_data = 8'hC0 + tx_cnt;

   always @(posedge clk) begin
      if (rd_ld) begin
         rd_byte <= rd_seed;
         tx_cnt  <= 8'h00;
      end else begin
         if (nf_re)     rd_byte <= rd_byte + 8'd1;
         if (buf_tx_rd) tx_cnt  <= tx_cnt + 8'd1;
      end
   end

   // bus monitor
   logic       mon_clr = 1'b0;
   int         cle_n, ale_n, we_n, re_n, rx_n, done_n, cyc, first_cle;
   logic [7:0] last_cle;
   logic [7:0] we_log [32];
   logic [7:0] rx_log [32];

   always @(posedge clk) begin
      if (mon_clr) begin
         cle_n <= 0; ale_n <= 0; we_n <= 0; re_n <= 0; rx_n <= 0; done_n <= 0;
         cyc <= 0; first_cle <= -1; last_cle <= 8'h00;
      end else begin
         cyc <= cyc + 1;
         if (nf_cle) begin
            cle_n    <= cle_n + 1;
            last_cle <= nf_dout;
            if (cle_n == 0) first_cle <= cyc;
         end
         if (nf_ale) ale_n <= ale_n + 1;
         if (nf_we) begin
            if (we_n < 32) we_log[we_n] <= nf_dout;
            we_n <= we_n + 1;
         end
         if (nf_re) re_n <= re_n + 1;
         if (buf_rx_wr) begin
            if (rx_n < 32) rx_log[rx_n] <= buf_rx_data;
            rx_n <= rx_n + 1;
         end
         if (done) done_n <= done_n + 1;
      end
   end

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic report;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   task automatic launch(input logic [31:0] op);
      @(negedge clk);
      mon_clr = 1'b1;
      @(negedge clk);
      mon_clr  = 1'b0;
      seq_word = op;
      start    = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done;
      for (int k = 0; k < 4000; k++) begin
         if (done) break;
         @(negedge clk);
      end
      @(negedge clk);
   endtask

   task automatic seed(input logic [7:0] s);
      @(negedge clk);
      rd_seed = s;
      rd_ld   = 1'b1;
      @(negedge clk);
      rd_ld = 1'b0;
   endtask

   task automatic sw_write(input logic [31:0] v);
      @(negedge clk);
      udr_we    = 1'b1;
      udr_wdata = v;
      @(negedge clk);
      udr_we = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         report();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10: reset state
      check("R10 busy", {31'b0, busy}, 32'd0);
      check("R10 done", {31'b0, done}, 32'd0);
      check("R10 tmo", {31'b0, tmo_flag}, 32'd0);
      check("R10 strobes", {28'b0, nf_cle, nf_ale, nf_we, nf_re}, 32'd0);
      check("R10 udr", udr_q, 32'd0);
      rst_n = 1'b1;
      seed(8'h10);

      // vector table: R1 R2 R3 R4 R6 R7
      foreach (VT[i]) begin
         launch(VT[i].op);
         wait_done();
         check($sformatf("R1 R3 vec%0d cle count", i), cle_n, VT[i].cle);
         check($sformatf("R4 vec%0d ale count", i), ale_n, VT[i].ale);
         check($sformatf("R6 vec%0d we count", i), we_n, VT[i].we);
         check($sformatf("R7 vec%0d re count", i), re_n, VT[i].re);
         check($sformatf("R3 vec%0d last cmd", i), {24'b0, last_cle}, {24'b0, VT[i].lastc});
         check($sformatf("R2 vec%0d done once", i), done_n, 1);
         check($sformatf("R2 vec%0d busy low", i), {31'b0, busy}, 32'd0);
      end

      // R3 R4: byte order, wide column and three row bytes
      launch(32'h4120_0000);
      wait_done();
      check("R3 cmd byte0", {24'b0, we_log[0]}, 32'h60);
      check("R4 col lsb first", {24'b0, we_log[1]}, 32'hEF);
      check("R4 col msb", {24'b0, we_log[2]}, 32'hBE);
      check("R4 row b0", {24'b0, we_log[3]}, 32'h56);
      check("R4 row b1", {24'b0, we_log[4]}, 32'h34);
      check("R4 row b2", {24'b0, we_log[5]}, 32'h12);

      // R4: narrow column, one row byte
      col_wide = 1'b0;
      row_len  = 2'd0;
      launch(32'h1200_0000);
      wait_done();
      check("R4 narrow ale count", ale_n, 2);
      check("R4 narrow col byte", {24'b0, we_log[0]}, 32'hEF);
      check("R4 narrow row byte", {24'b0, we_log[1]}, 32'h56);
      col_wide = 1'b1;
      row_len  = 2'd2;

      // R5: shared user-register pointer
      sw_write(32'h1122_3344);
      seed(8'hA0);
      launch(32'h39BB_0000);
      wait_done();
      check("R5 user addr byte", {24'b0, we_log[0]}, 32'h11);
      check("R5 single write byte", {24'b0, we_log[1]}, 32'h22);
      check("R5 single reads", udr_q, 32'h1122_A0A1);
      launch(32'h9000_0000);
      wait_done();
      check("R5 pointer restarts", {24'b0, we_log[0]}, 32'h11);

      // R6: bulk write from the stream
      seed(8'h00);
      launch(32'h8000_0000);
      wait_done();
      check("R6 bulk wr count", we_n, 4);
      check("R6 bulk wr first", {24'b0, we_log[0]}, 32'hC0);
      check("R6 bulk wr last", {24'b0, we_log[3]}, 32'hC3);

      // R6: bulk read to the stream
      xfer_len = 12'd3;
      seed(8'h50);
      launch(32'hA000_0000);
      wait_done();
      check("R6 bulk rd count", rx_n, 3);
      check("R6 bulk rd first", {24'b0, rx_log[0]}, 32'h50);
      check("R6 bulk rd last", {24'b0, rx_log[2]}, 32'h52);

      // R6: zero length moves nothing
      xfer_len = 12'd0;
      launch(32'h8400_0000);
      wait_done();
      check("R6 zero len we", we_n, 1);
      check("R6 zero len cle", cle_n, 1);
      check("R6 zero len done", done_n, 1);
      xfer_len = 12'd4;

      // R7 R9: wait for ready; competing start and software write are lost
      nf_rb     = 1'b0;
      tmo_limit = 16'd1000;
      launch(32'hD000_0000);
      repeat (30) @(negedge clk);
      check("R7 still waiting", {31'b0, busy}, 32'd1);
      check("R7 no cmd yet", cle_n, 0);
      seq_word = 32'h7000_0000;
      start    = 1'b1;
      udr_we    = 1'b1;
      udr_wdata = 32'hDEAD_BEEF;
      @(negedge clk);
      start  = 1'b0;
      udr_we = 1'b0;
      nf_rb  = 1'b1;
      wait_done();
      check("R7 cmd after ready", {24'b0, last_cle}, 32'hD0);
      check("R9 start ignored", cle_n, 1);
      check("R9 one done", done_n, 1);
      check("R9 udr write ignored", udr_q, 32'h1122_A0A1);
      check("R8 no timeout", {31'b0, tmo_flag}, 32'd0);

      // R8: timeout fires, step continues
      nf_rb     = 1'b0;
      tmo_limit = 16'd10;
      launch(32'hC000_0000);
      wait_done();
      check("R8 tmo flag", {31'b0, tmo_flag}, 32'd1);
      check("R8 cmd issued", {24'b0, last_cle}, 32'h60);
      check("R8 waited long enough", {31'b0, first_cle >= 10}, 32'd1);
      check("R8 not waited too long", {31'b0, first_cle <= 16}, 32'd1);
      nf_rb = 1'b1;
      launch(32'h7000_0000);
      wait_done();
      check("R8 flag cleared by start", {31'b0, tmo_flag}, 32'd0);

      finished = 1'b1;
      report();
      $finish;
   end

endmodule